// File: doc/BRIEF.md
# Dual-Line Left-Justified Audio Deserializer

This block takes two serial data lines from external audio converters and turns each into a pair of 24-bit samples per frame, one for the left channel and one for the right. Both lines share one bit clock and one frame clock. Two such clock pairs arrive at the block: one from the playback side and one from the capture side. A configuration input chooses which pair is used. The receive format is fixed. Samples are left-justified and sent MSB first. A high frame clock marks the left half and a low frame clock marks the right half.

All serial inputs are oversampled in the block's own system clock through a synchronizer chain. Edges are found in the system-clock domain, so no logic runs on the external clocks. The block counts bit clocks from one rising frame edge to the next. A frame of a legal length, in a supported speed mode, releases all four words together with a one-cycle strobe. Frames of an illegal length raise a sticky error. A quad-speed setting raises a mode error and suppresses output.

Top module: `dual_lj_deser`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it rises, `smp_valid`, `ratio_err`, `mode_err` and both data buses are 0. `clk_sel` is captured while in reset.
- R2: For each line, the 24 bits after a frame-clock edge are taken on the first 24 rising bit-clock edges, MSB first. Bits taken while the frame clock is high form the left word and bits taken while it is low form the right word.
- R3: Bit-clock edges after the 24th in a half-frame do not change the captured words.
- R4: Line k is placed at bits [24k+23:24k] of `left_data` and `right_data`. The two lines are captured in parallel from their own `sdin` bits.
- R5: On the rising frame edge that ends a complete frame of legal length, all four words are loaded together and `smp_valid` is high for exactly one system cycle.
- R6: `speed` code 0 is single speed and accepts 64 or 128 bit clocks per frame. Code 1 is double speed and accepts only 64. A 128-clock frame at code 1 sets `ratio_err` and produces no strobe.
- R7: A frame whose bit-clock count is neither 64 nor 128 sets `ratio_err` and produces no strobe. `ratio_err` stays high until reset, and later legal frames still produce strobes.
- R8: `speed` codes 2 (quad) and 3 (unused) drive `mode_err` high and produce no strobe. `smp_valid` is never high in the cycle after `mode_err` is high.
- R9: With `clk_sel`=1 the block uses `dac_bclk`/`dac_fclk`. With `clk_sel`=0 it uses `adc_bclk`/`adc_fclk`. Activity on the other pair produces no strobe.
- R10: A change of `clk_sel` after reset discards the frame in progress. No strobe occurs in the cycle after the change. Capture restarts at the next rising frame edge, and the first strobe comes at the end of the first full frame after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for oversampling |
| rst_n | input | 1 | Synchronous active-low reset |
| dac_bclk | input | 1 | Playback-side bit clock |
| dac_fclk | input | 1 | Playback-side frame clock |
| adc_bclk | input | 1 | Capture-side bit clock |
| adc_fclk | input | 1 | Capture-side frame clock |
| clk_sel | input | 1 | Clock pair select (1 = playback side) |
| speed | input | 2 | Speed mode: 0 single, 1 double, 2 quad, 3 unused |
| sdin | input | NUM_LINES | Serial data lines |
| smp_valid | output | 1 | One-cycle strobe when new words are presented |
| left_data | output | NUM_LINES*SAMPLE_W | Left words, line k at bits 24k and up |
| right_data | output | NUM_LINES*SAMPLE_W | Right words, line k at bits 24k and up |
| ratio_err | output | 1 | Sticky flag for an illegal bit-clock count |
| mode_err | output | 1 | Unsupported speed mode selected |

## Verification
The bench uses the default parameters: two lines, 24-bit words, ratios of 64 and 128, and a two-stage synchronizer. Because 24 is less than half of 64, every legal half-frame carries trailing bits. The bench fills those with junk so that their rejection can be seen. Both legal ratios and an illegal 80-clock frame fall within one short run, as do both clock pairs. Each bit-clock phase lasts two system cycles, which is the shortest phase the synchronizer resolves.

// File: rtl/lj_deser_pkg.sv
// Shared types for the left-justified deserializer.
package lj_deser_pkg;
    // Speed mode codes as seen on the speed input.
    typedef enum logic [1:0] {
        SPD_SINGLE = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2,
        SPD_RSVD   = 2'd3
    } speed_e;
endpackage

// File: rtl/lj_sync.sv
// Multi-stage synchronizer for asynchronous serial inputs.
// Assumes each input holds a level for at least two clk cycles.
module lj_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [STAGES];

    // Shift the raw inputs through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
        end else begin
            pipe[0] <= din;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/lj_lane.sv
// One data line: shifts bits MSB first into a left or right word.
// Assumes take is already limited to the first SAMPLE_W bits of a half.
module lj_lane #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic                left_half,
    input  logic                din,
    output logic [SAMPLE_W-1:0] left_word,
    output logic [SAMPLE_W-1:0] right_word
);
    // Shift the sampled bit into the word of the current half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_word  <= '0;
            right_word <= '0;
        end else if (take) begin
            if (left_half) left_word  <= {left_word[SAMPLE_W-2:0], din};
            else           right_word <= {right_word[SAMPLE_W-2:0], din};
        end
    end

    assert_lane_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(left_word) && $stable(right_word)));
    assert_lane_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && left_half) |=> $stable(right_word));
endmodule

// File: rtl/lj_ratio_mon.sv
// Measures bit clocks per frame, judges them against the speed mode,
// and tells the top when a complete legal frame has ended.
// Assumes a frame runs from one rising frame edge to the next.
module lj_ratio_mon
    import lj_deser_pkg::*;
#(
    parameter int RATIO_LO = 64,
    parameter int RATIO_HI = 128
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   bclk_rise,
    input  logic   fclk_rise,
    input  speed_e speed,
    output logic   frame_ok,
    output logic   ratio_err,
    output logic   mode_err
);
    localparam int              CNT_W = $clog2(RATIO_HI) + 2;
    localparam logic [CNT_W-1:0] LO_C = CNT_W'(RATIO_LO);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(RATIO_HI);

    speed_e           spd_q;
    logic             armed;
    logic [CNT_W-1:0] fcnt;
    logic             mode_bad;
    logic             allowed;

    assign mode_bad = (spd_q == SPD_QUAD) || (spd_q == SPD_RSVD);
    assign allowed  = (fcnt == LO_C) || ((fcnt == HI_C) && (spd_q == SPD_SINGLE));
    assign frame_ok = armed && fclk_rise && !clr && !mode_bad && allowed;
    assign mode_err = mode_bad;

    // Register the speed mode.
    always_ff @(posedge clk) begin
        if (!rst_n) spd_q <= SPD_SINGLE;
        else        spd_q <= speed;
    end

    // Count bit clocks per frame, arm on the first frame edge, flag bad lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            fcnt      <= '0;
            ratio_err <= 1'b0;
        end else if (clr) begin
            armed <= 1'b0;
            fcnt  <= '0;
        end else if (fclk_rise) begin
            fcnt  <= '0;
            armed <= 1'b1;
            if (armed && !mode_bad && !allowed) ratio_err <= 1'b1;
        end else if (bclk_rise && (fcnt != '1)) begin
            fcnt <= fcnt + 1'b1;
        end
    end

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_err |=> ratio_err);
    assert_err_at_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ratio_err) |-> $past(fclk_rise));
endmodule

// File: rtl/dual_lj_deser.sv
// Dual-line left-justified deserializer. Oversamples two clock pairs
// and the data lines in clk, picks one pair with clk_sel, and presents
// left/right words of every line with a one-cycle strobe per legal frame.
// Assumes every external clock phase lasts at least two clk cycles.
module dual_lj_deser
    import lj_deser_pkg::*;
#(
    parameter int NUM_LINES   = 2,
    parameter int SAMPLE_W    = 24,
    parameter int RATIO_LO    = 64,
    parameter int RATIO_HI    = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          dac_bclk,
    input  logic                          dac_fclk,
    input  logic                          adc_bclk,
    input  logic                          adc_fclk,
    input  logic                          clk_sel,
    input  logic [1:0]                    speed,
    input  logic [NUM_LINES-1:0]          sdin,
    output logic                          smp_valid,
    output logic [NUM_LINES*SAMPLE_W-1:0] left_data,
    output logic [NUM_LINES*SAMPLE_W-1:0] right_data,
    output logic                          ratio_err,
    output logic                          mode_err
);
    localparam int              HC_W   = $clog2(RATIO_HI) + 1;
    localparam int              BUS_W  = NUM_LINES * SAMPLE_W;
    localparam logic [HC_W-1:0] HC_LIM = HC_W'(SAMPLE_W);

    // Clock vector order: 0 dac bit, 1 dac frame, 2 adc bit, 3 adc frame.
    logic [3:0]           ck_cur;
    logic [3:0]           ck_prv;
    logic [3:0]           ck_rise;
    logic [NUM_LINES-1:0] dat_cur;
    logic                 sel_q;
    logic                 resync;
    logic                 b_rise;
    logic                 f_rise;
    logic                 f_tgl;
    logic                 f_lvl;
    logic [HC_W-1:0]      hcnt;
    logic                 take;
    logic                 frame_ok;
    logic [BUS_W-1:0]     lane_l;
    logic [BUS_W-1:0]     lane_r;

    lj_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_ck_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({adc_fclk, adc_bclk, dac_fclk, dac_bclk}),
        .dout (ck_cur)
    );

    lj_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_dat_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sdin),
        .dout (dat_cur)
    );

    // Keep the previous synchronized clock levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ck_prv <= '0;
        else        ck_prv <= ck_cur;
    end

    assign ck_rise = ck_cur & ~ck_prv;

    // Capture the select bit in reset and follow later changes as resyncs.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= clk_sel;
        else if (resync) sel_q <= clk_sel;
    end

    assign resync = (clk_sel != sel_q);

    // Pick the edges of the selected clock pair after edge detection.
    always_comb begin
        if (sel_q) begin
            b_rise = ck_rise[0];
            f_rise = ck_rise[1];
            f_tgl  = ck_cur[1] ^ ck_prv[1];
            f_lvl  = ck_cur[1];
        end else begin
            b_rise = ck_rise[2];
            f_rise = ck_rise[3];
            f_tgl  = ck_cur[3] ^ ck_prv[3];
            f_lvl  = ck_cur[3];
        end
    end

    // Count bit clocks within the current half-frame, restart on frame edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                        hcnt <= '0;
        else if (f_tgl)                    hcnt <= '0;
        else if (b_rise && (hcnt != '1))   hcnt <= hcnt + 1'b1;
    end

    assign take = b_rise && (hcnt < HC_LIM);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
        lj_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .take      (take),
            .left_half (f_lvl),
            .din       (dat_cur[g]),
            .left_word (lane_l[g*SAMPLE_W +: SAMPLE_W]),
            .right_word(lane_r[g*SAMPLE_W +: SAMPLE_W])
        );
    end

    lj_ratio_mon #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (resync),
        .bclk_rise(b_rise),
        .fclk_rise(f_rise),
        .speed    (speed_e'(speed)),
        .frame_ok (frame_ok),
        .ratio_err(ratio_err),
        .mode_err (mode_err)
    );

    // Load all words together and strobe once per accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid  <= 1'b0;
            left_data  <= '0;
            right_data <= '0;
        end else begin
            smp_valid <= frame_ok;
            if (frame_ok) begin
                left_data  <= lane_l;
                right_data <= lane_r;
            end
        end
    end

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);
    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> ($stable(left_data) && $stable(right_data)));
    assert_resync_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != sel_q) |=> !smp_valid);
    assert_no_valid_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> !smp_valid);
endmodule

// File: tb/sim_dual_lj_deser.sv
`timescale 1ns/1ps
module sim_dual_lj_deser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbclk = 1'b0, dfclk = 1'b0, abclk = 1'b0, afclk = 1'b0;
    logic        sel = 1'b0;
    logic [1:0]  spd = 2'd0;
    logic [1:0]  sd = 2'b00;
    logic        smp_valid, ratio_err, mode_err;
    logic [47:0] left_data, right_data;

    int n_chk = 0;
    int n_fail = 0;
    int vcnt = 0;
    logic [47:0] cap_l = '0, cap_r = '0;

    always #4 clk = ~clk;

    dual_lj_deser u0 (
        .clk(clk), .rst_n(rst_n),
        .dac_bclk(dbclk), .dac_fclk(dfclk),
        .adc_bclk(abclk), .adc_fclk(afclk),
        .clk_sel(sel), .speed(spd), .sdin(sd),
        .smp_valid(smp_valid), .left_data(left_data), .right_data(right_data),
        .ratio_err(ratio_err), .mode_err(mode_err)
    );

    // Record every strobe and the words shown with it.
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            vcnt  <= vcnt + 1;
            cap_l <= left_data;
            cap_r <= right_data;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic bit_at(input logic [23:0] w, input int i);
        if (i < 24) return w[23-i];
        return ((i % 3) == 0);
    endfunction

    task automatic slot(input bit dac, input bit fv, input bit d0, input bit d1);
        if (dac) begin dbclk = 1'b0; dfclk = fv; end
        else     begin abclk = 1'b0; afclk = fv; end
        sd = {d1, d0};
        tick(2);
        if (dac) dbclk = 1'b1; else abclk = 1'b1;
        tick(2);
    endtask

    // One frame: left half, right half, then the closing rising frame edge.
    task automatic send_frame(input bit dac, input int ratio,
                              input logic [23:0] l0, r0, l1, r1, input int glitch);
        for (int i = 0; i < ratio/2; i++) begin
            if (i == glitch) begin sel = ~sel; tick(2); sel = ~sel; tick(2); end
            slot(dac, 1'b1, bit_at(l0, i), bit_at(l1, i));
        end
        for (int i = 0; i < ratio/2; i++)
            slot(dac, 1'b0, bit_at(r0, i), bit_at(r1, i));
        if (dac) begin dbclk = 1'b0; dfclk = 1'b1; end
        else     begin abclk = 1'b0; afclk = 1'b1; end
        tick(8);
    endtask

    task automatic park(input bit dac);
        if (dac) begin dbclk = 1'b0; dfclk = 1'b0; end
        else     begin abclk = 1'b0; afclk = 1'b0; end
        tick(6);
    endtask

    task automatic do_reset(input bit s, input logic [1:0] m);
        rst_n = 1'b0; sel = s; spd = m;
        dbclk = 0; dfclk = 0; abclk = 0; afclk = 0; sd = 0;
        tick(4);
        rst_n = 1'b1;
        tick(3);
    endtask

    task automatic good_frame(input bit dac, input int ratio, input string req,
                              input logic [23:0] l0, r0, l1, r1);
        int v0;
        v0 = vcnt;
        send_frame(dac, ratio, l0, r0, l1, r1, -1);
        chk(req, "one strobe per frame", 64'(vcnt - v0), 64'd1);
        chk(req, "left words", 64'(cap_l), 64'({l1, l0}));
        chk(req, "right words", 64'(cap_r), 64'({r1, r0}));
    endtask

    task automatic t_reset;
        do_reset(1'b0, 2'd0);
        chk("R1", "valid after reset", 64'(smp_valid), 64'd0);
        chk("R1", "ratio_err after reset", 64'(ratio_err), 64'd0);
        chk("R1", "mode_err after reset", 64'(mode_err), 64'd0);
        chk("R1", "data after reset", 64'(left_data | right_data), 64'd0);
    endtask

    task automatic t_single64;
        good_frame(1'b0, 64, "R2 R5 R9", 24'hA5C3F0, 24'h123456, 24'h0F1E2D, 24'hFEDCBA);
        good_frame(1'b0, 64, "R4", 24'h800001, 24'h7FFFFE, 24'h000000, 24'hFFFFFF);
    endtask

    task automatic t_single128;
        good_frame(1'b0, 128, "R3 R6", 24'h3C3C3C, 24'hC0FFEE, 24'h5A5A5A, 24'h010203);
        chk("R6", "no ratio error at 128 single", 64'(ratio_err), 64'd0);
    endtask

    task automatic t_double;
        int v0;
        spd = 2'd1; tick(3);
        good_frame(1'b0, 64, "R6", 24'h111111, 24'h222222, 24'h333333, 24'h444444);
        v0 = vcnt;
        send_frame(1'b0, 128, 24'hABCDEF, 24'h1, 24'h2, 24'h3, -1);
        chk("R6", "no strobe at 128 double", 64'(vcnt - v0), 64'd0);
        chk("R6", "ratio_err at 128 double", 64'(ratio_err), 64'd1);
        chk("R6", "words kept", 64'(cap_l), 64'({24'h333333, 24'h111111}));
    endtask

    task automatic t_bad_ratio;
        int v0;
        do_reset(1'b0, 2'd0);
        chk("R1", "reset clears ratio_err", 64'(ratio_err), 64'd0);
        good_frame(1'b0, 64, "R7", 24'h0A0B0C, 24'h0D0E0F, 24'h102030, 24'h405060);
        v0 = vcnt;
        send_frame(1'b0, 80, 24'h999999, 24'h888888, 24'h777777, 24'h666666, -1);
        chk("R7", "no strobe at 80", 64'(vcnt - v0), 64'd0);
        chk("R7", "ratio_err at 80", 64'(ratio_err), 64'd1);
        good_frame(1'b0, 64, "R7", 24'hBEEF01, 24'hCAFE02, 24'hD00D03, 24'hF00D04);
        chk("R7", "ratio_err sticky", 64'(ratio_err), 64'd1);
    endtask

    task automatic t_quad;
        int v0;
        do_reset(1'b0, 2'd0);
        good_frame(1'b0, 64, "R8", 24'h13579B, 24'h2468AC, 24'hECA864, 24'hB97531);
        spd = 2'd2; tick(3);
        chk("R8", "mode_err quad", 64'(mode_err), 64'd1);
        v0 = vcnt;
        send_frame(1'b0, 64, 24'h1, 24'h2, 24'h3, 24'h4, -1);
        chk("R8", "no strobe quad", 64'(vcnt - v0), 64'd0);
        spd = 2'd3; tick(3);
        chk("R8", "mode_err code 3", 64'(mode_err), 64'd1);
        send_frame(1'b0, 64, 24'h5, 24'h6, 24'h7, 24'h8, -1);
        chk("R8", "no strobe code 3", 64'(vcnt - v0), 64'd0);
        chk("R8", "no ratio error in quad", 64'(ratio_err), 64'd0);
        spd = 2'd0; tick(3);
        chk("R8", "mode_err cleared", 64'(mode_err), 64'd0);
        good_frame(1'b0, 64, "R8", 24'hAAAAAA, 24'h555555, 24'hF0F0F0, 24'h0F0F0F);
    endtask

    task automatic t_select;
        int v0;
        park(1'b1);
        v0 = vcnt;
        send_frame(1'b1, 64, 24'h1, 24'h2, 24'h3, 24'h4, -1);
        chk("R9", "other pair ignored", 64'(vcnt - v0), 64'd0);
        chk("R9", "words unchanged", 64'(cap_l), 64'({24'hF0F0F0, 24'hAAAAAA}));
        sel = 1'b1; tick(2);
        park(1'b1);
        good_frame(1'b1, 64, "R9 R10", 24'h654321, 24'h0FEDCB, 24'h9ABCDE, 24'h246802);
    endtask

    task automatic t_resync;
        int v0;
        v0 = vcnt;
        send_frame(1'b1, 64, 24'h7, 24'h8, 24'h9, 24'hA, 10);
        chk("R10", "frame with select change dropped", 64'(vcnt - v0), 64'd0);
        good_frame(1'b1, 64, "R10", 24'hFACE01, 24'hBEAD02, 24'hC0DE03, 24'hDEAF04);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_single64();
        t_single128();
        t_double();
        t_bad_ratio();
        t_quad();
        t_select();
        t_resync();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule